// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block models the control side of a NOR-style flash device. It sits behind a bus with active-low chip select, write strobe and read strobe. It also holds a small on-chip register-file array that stands in for the flash cells. Data is never written straight into the array. Bus writes feed a command decoder, which recognises the two unlock writes, the command byte and the address/data write that follows. The decoder then starts a timed program or erase job. A program can only clear bits. An erase first drives every word of the chosen sectors to zero and then returns them to all ones.

While a job runs, the ready output is low. Reads then return a status byte instead of array contents: bit 7 is a data-poll bit and bit 6 flips on each status read. A bypass mode cuts a program down to two writes. A running erase can be parked, so that other sectors can be read or programmed, and then continued. Each sector has a protection input. A low-supply input blocks all bus writes. The active-low reset aborts any job and returns the block to plain array reads.

Top module: `flash_cmd_ctl`

## Requirements
- R1: After reset the ready output is 1, and reads return array data with no toggling. A reset during a job aborts it: the target word keeps its old value and ready is 1 at once.
- R2: A program is the write sequence 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555, then data@address. The address is compared on its low 11 bits. After the job the word holds old AND data.
- R3: A program keeps ready low for exactly PROG_CYC cycles. An erase keeps it low for SECTORS*SECTOR_WORDS+ERASE_CYC cycles. Both counts start at the clock edge that takes the last write.
- R4: While a program runs, read bit 7 is the inverse of bit 7 of the data being written. Bit 6 differs between any two back-to-back status reads. Once ready, two reads of a word give the same value.
- R5: The write sequence unlock, unlock, 0x20@0x555 enters bypass mode. In bypass mode, 0xA0 at any address followed by data@address is a program. The writes 0x90 then 0x00 leave bypass mode, and a two-write program is then ignored.
- R6: The sector erase sequence is unlock, unlock, 0x80@0x555, unlock, unlock, 0x30 at any address in the sector. The sector number is word address bits [5:4]. Afterwards every word in that sector reads 0xFF and other sectors are unchanged. Status bit 7 reads 0 while the erase runs.
- R7: Writing 0x10@0x555 in place of 0x30 erases every unprotected sector.
- R8: Writing 0xB0 during an erase sets ready high at the next edge. While the erase is parked, reads of the sectors being erased return bit 7 = 1. Other sectors can be read and programmed, and a program into an erasing sector is refused. Writing 0x30 continues the erase, which then completes.
- R9: A sector whose protect bit is 1 refuses both program and sector erase: ready stays high and its data is unchanged.
- R10: While low_supply is 1, bus writes are ignored and leave no partial sequence behind.
- R11: A write that breaks a sequence, or a 0xF0 write, returns the decoder to array read, and the writes that follow are not taken as part of the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low; one write per cycle it is low |
| rd_n | input | 1 | Read strobe, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | DW | Write data or command byte |
| rdata | output | DW | Array data or status byte during reads, else 0 |
| ready | output | 1 | 1 when idle or parked, 0 while a job runs |
| low_supply | input | 1 | Low-supply detect; blocks writes |
| protect | input | SECTORS | Per-sector protection |

## Verification
On every cycle, the assertions check four things: low_supply never lets a job request through, a protected sector never starts a program, a program never overlaps a running erase, and the toggle bit changes between consecutive busy reads. A parked erase must always have an erase pending. Only the bench scenarios can show the results in the array: the AND rule of programming, the preprogram-then-erase outcome per sector, exact busy lengths, and a resumed erase finishing correctly. They also show what reset and broken sequences leave behind.

// File: rtl/flc_pkg.sv
package flc_pkg;
   typedef enum logic [2:0] {
      SQ_IDLE, SQ_U1, SQ_U2, SQ_PADDR, SQ_E1, SQ_E2, SQ_E3, SQ_BX
   } seq_t;

   localparam logic [10:0] UL_ADDR1 = 11'h555;
   localparam logic [10:0] UL_ADDR2 = 11'h2AA;
   localparam logic [7:0]  UL_KEY1  = 8'hAA;
   localparam logic [7:0]  UL_KEY2  = 8'h55;
   localparam logic [7:0]  OP_PROG   = 8'hA0;
   localparam logic [7:0]  OP_ERASE  = 8'h80;
   localparam logic [7:0]  OP_CHIP   = 8'h10;
   localparam logic [7:0]  OP_SECT   = 8'h30;
   localparam logic [7:0]  OP_BYP_IN = 8'h20;
   localparam logic [7:0]  OP_BYP_X1 = 8'h90;
   localparam logic [7:0]  OP_BYP_X2 = 8'h00;
   localparam logic [7:0]  OP_PARK   = 8'hB0;
   localparam logic [7:0]  OP_CONT   = 8'h30;
   localparam logic [7:0]  OP_CANCEL = 8'hF0;
endpackage

// File: rtl/flc_seq.sv
module flc_seq
   import flc_pkg::*;
#(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        cmd,
   input  logic              lock,
   input  logic              erase_run,
   input  logic              in_park,
   output logic              req_prog,
   output logic              req_serase,
   output logic              req_cerase,
   output logic              req_park,
   output logic              req_cont
);
   seq_t st, st_nxt;
   logic byp, byp_nxt;
   logic at1, at2;

   assign at1 = (addr[10:0] == UL_ADDR1);
   assign at2 = (addr[10:0] == UL_ADDR2);

   always_comb begin
      st_nxt     = st;
      byp_nxt    = byp;
      req_prog   = 1'b0;
      req_serase = 1'b0;
      req_cerase = 1'b0;
      req_park   = 1'b0;
      req_cont   = 1'b0;
      if (wr) begin
         st_nxt = SQ_IDLE;
         if (lock) begin
            req_park = erase_run && (cmd == OP_PARK);
         end else begin
            case (st)
               SQ_IDLE: begin
                  if (at1 && cmd == UL_KEY1)         st_nxt = SQ_U1;
                  else if (byp && cmd == OP_PROG)    st_nxt = SQ_PADDR;
                  else if (byp && cmd == OP_BYP_X1)  st_nxt = SQ_BX;
                  else if (in_park && cmd == OP_CONT) req_cont = 1'b1;
               end
               SQ_U1:  if (at2 && cmd == UL_KEY2) st_nxt = SQ_U2;
               SQ_U2: begin
                  if (at1 && cmd == OP_PROG)                 st_nxt = SQ_PADDR;
                  else if (at1 && cmd == OP_ERASE && !in_park) st_nxt = SQ_E1;
                  else if (at1 && cmd == OP_BYP_IN)          byp_nxt = 1'b1;
               end
               SQ_PADDR: req_prog = 1'b1;
               SQ_E1:  if (at1 && cmd == UL_KEY1) st_nxt = SQ_E2;
               SQ_E2:  if (at2 && cmd == UL_KEY2) st_nxt = SQ_E3;
               SQ_E3: begin
                  if (at1 && cmd == OP_CHIP) req_cerase = 1'b1;
                  else if (cmd == OP_SECT)   req_serase = 1'b1;
               end
               SQ_BX:  if (cmd == OP_BYP_X2) byp_nxt = 1'b0;
               default: st_nxt = SQ_IDLE;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= SQ_IDLE;
         byp <= 1'b0;
      end else begin
         st  <= st_nxt;
         byp <= byp_nxt;
      end
   end
endmodule

// File: rtl/flc_core.sv
module flc_core #(
   parameter int SECTORS      = 4,
   parameter int SECTOR_WORDS = 16,
   parameter int DW           = 8,
   parameter int PROG_CYC     = 6,
   parameter int ERASE_CYC    = 10,
   parameter int AW           = $clog2(SECTORS * SECTOR_WORDS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_prog,
   input  logic               req_serase,
   input  logic               req_cerase,
   input  logic               req_park,
   input  logic               req_cont,
   input  logic [AW-1:0]      req_addr,
   input  logic [DW-1:0]      req_data,
   input  logic [SECTORS-1:0] protect,
   input  logic [AW-1:0]      rd_addr,
   output logic               prog_busy,
   output logic               erase_busy,
   output logic               parked,
   output logic               prog_bit7,
   output logic [SECTORS-1:0] emask,
   output logic [DW-1:0]      rd_word
);
   localparam int NWORDS = SECTORS * SECTOR_WORDS;
   localparam int SW     = $clog2(SECTOR_WORDS);
   localparam int SECW   = AW - SW;
   localparam int ETOT   = NWORDS + ERASE_CYC;
   localparam int ECW    = $clog2(ETOT + 1);
   localparam int PCW    = $clog2(PROG_CYC + 1);

   generate
      if (PROG_CYC < 1 || ERASE_CYC < 1) begin : g_bad_timing
         $error("flc_core: job lengths must be at least one cycle");
      end
      if (AW != $clog2(NWORDS)) begin : g_bad_aw
         $error("flc_core: AW does not match the array size");
      end
   endgenerate

   logic [DW-1:0]      mem [NWORDS];
   logic [PCW-1:0]     pcnt;
   logic [AW-1:0]      paddr;
   logic [DW-1:0]      pdata;
   logic [ECW-1:0]     ecnt;
   logic [AW-1:0]      widx;
   logic [SECW-1:0]    req_sec;
   logic               prog_ok, serase_ok, cerase_ok, pre_phase, erase_step;

   assign req_sec    = req_addr[AW-1:SW];
   assign prog_ok    = req_prog && !protect[req_sec] && !(erase_busy && emask[req_sec]);
   assign serase_ok  = req_serase && !protect[req_sec] && !erase_busy;
   assign cerase_ok  = req_cerase && (|(~protect)) && !erase_busy;
   assign pre_phase  = (ecnt >= ECW'(ERASE_CYC));
   assign erase_step = erase_busy && !parked;
   assign prog_bit7  = pdata[DW-1 - (DW-8)];
   assign rd_word    = mem[rd_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog_busy <= 1'b0;
         pcnt      <= '0;
         paddr     <= '0;
         pdata     <= '0;
      end else if (prog_ok) begin
         prog_busy <= 1'b1;
         pcnt      <= PCW'(PROG_CYC - 1);
         paddr     <= req_addr;
         pdata     <= req_data;
      end else if (prog_busy) begin
         if (pcnt == '0) prog_busy <= 1'b0;
         else            pcnt <= pcnt - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         erase_busy <= 1'b0;
         parked     <= 1'b0;
         emask      <= '0;
         ecnt       <= '0;
         widx       <= '0;
      end else if (serase_ok || cerase_ok) begin
         erase_busy <= 1'b1;
         parked     <= 1'b0;
         emask      <= serase_ok ? (SECTORS'(1) << req_sec) : ~protect;
         ecnt       <= ECW'(ETOT - 1);
         widx       <= '0;
      end else if (erase_busy) begin
         if (req_park && !parked) begin
            parked <= 1'b1;
         end else if (req_cont && parked) begin
            parked <= 1'b0;
         end else if (!parked) begin
            if (pre_phase) widx <= widx + 1'b1;
            if (ecnt == '0) begin
               erase_busy <= 1'b0;
               emask      <= '0;
            end else begin
               ecnt <= ecnt - 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (prog_busy && pcnt == '0)
         mem[paddr] <= mem[paddr] & pdata;
      if (erase_step && !req_park && pre_phase && emask[widx[AW-1:SW]])
         mem[widx] <= '0;
      if (erase_step && !req_park && ecnt == '0) begin
         for (int w = 0; w < NWORDS; w++) begin
            if (emask[SECW'(w >> SW)]) mem[AW'(w)] <= '1;
         end
      end
   end

   // R9: a program request into a protected sector never starts a job
   a_r9_protect_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (req_prog && protect[req_sec]) |=> !$rose(prog_busy));
   // R8: a program while an erase runs is only possible when parked
   a_r8_prog_only_parked: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_busy && erase_busy) |-> parked);
   // R8: parking requires a pending erase
   a_r8_park_needs_erase: assert property (@(posedge clk) disable iff (!rst_n)
      parked |-> erase_busy);
endmodule

// File: rtl/flash_cmd_ctl.sv
module flash_cmd_ctl #(
   parameter int ADDR_W       = 11,
   parameter int DW           = 8,
   parameter int SECTORS      = 4,
   parameter int SECTOR_WORDS = 16,
   parameter int PROG_CYC     = 6,
   parameter int ERASE_CYC    = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_n,
   input  logic               wr_n,
   input  logic               rd_n,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DW-1:0]      wdata,
   output logic [DW-1:0]      rdata,
   output logic               ready,
   input  logic               low_supply,
   input  logic [SECTORS-1:0] protect
);
   localparam int AW = $clog2(SECTORS * SECTOR_WORDS);
   localparam int SW = $clog2(SECTOR_WORDS);

   generate
      if (ADDR_W < 11) begin : g_bad_addr
         $error("flash_cmd_ctl: unlock addresses need 11 address bits");
      end
      if (DW < 8) begin : g_bad_dw
         $error("flash_cmd_ctl: command bytes need DW of at least 8");
      end
      if ((1 << SW) != SECTOR_WORDS || SECTORS < 2 || (SECTORS & (SECTORS - 1)) != 0) begin : g_bad_geom
         $error("flash_cmd_ctl: sector count and size must be powers of two");
      end
      if (AW > ADDR_W) begin : g_bad_span
         $error("flash_cmd_ctl: array larger than address space");
      end
   endgenerate

   logic wr, rd, busy_now, tog;
   logic req_prog, req_serase, req_cerase, req_park, req_cont;
   logic prog_busy, erase_busy, parked, prog_bit7;
   logic [SECTORS-1:0] emask;
   logic [DW-1:0] rd_word;
   logic [AW-SW-1:0] rsec;

   assign wr       = !cs_n && !wr_n && !low_supply;
   assign rd       = !cs_n && !rd_n && wr_n;
   assign busy_now = prog_busy || (erase_busy && !parked);
   assign ready    = !busy_now;
   assign rsec     = addr[AW-1:SW];

   flc_seq #(.ADDR_W(ADDR_W)) seq_i (
      .clk(clk), .rst_n(rst_n), .wr(wr), .addr(addr), .cmd(wdata[7:0]),
      .lock(busy_now), .erase_run(erase_busy && !parked && !prog_busy),
      .in_park(parked),
      .req_prog(req_prog), .req_serase(req_serase), .req_cerase(req_cerase),
      .req_park(req_park), .req_cont(req_cont)
   );

   flc_core #(
      .SECTORS(SECTORS), .SECTOR_WORDS(SECTOR_WORDS), .DW(DW),
      .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .AW(AW)
   ) core_i (
      .clk(clk), .rst_n(rst_n),
      .req_prog(req_prog), .req_serase(req_serase), .req_cerase(req_cerase),
      .req_park(req_park), .req_cont(req_cont),
      .req_addr(addr[AW-1:0]), .req_data(wdata), .protect(protect),
      .rd_addr(addr[AW-1:0]),
      .prog_busy(prog_busy), .erase_busy(erase_busy), .parked(parked),
      .prog_bit7(prog_bit7), .emask(emask), .rd_word(rd_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               tog <= 1'b0;
      else if (rd && busy_now)  tog <= ~tog;
   end

   always_comb begin
      if (!rd)                           rdata = '0;
      else if (prog_busy)                rdata = {~prog_bit7, tog, {(DW-2){1'b0}}};
      else if (erase_busy && !parked)    rdata = {1'b0, tog, {(DW-2){1'b0}}};
      else if (parked && emask[rsec])    rdata = {1'b1, tog, {(DW-2){1'b0}}};
      else                               rdata = rd_word;
   end

   // R10: a low supply never lets a job request through
   a_r10_low_supply_block: assert property (@(posedge clk) disable iff (!rst_n)
      low_supply |-> !(req_prog || req_serase || req_cerase || req_park || req_cont));
   // R4: back-to-back status reads show a changing bit 6
   a_r4_toggle_moves: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !ready && $past(rd && !ready && rst_n)) |-> (rdata[DW-2] != $past(rdata[DW-2])));
endmodule

// File: tb/flash_cmd_ctl_tb.sv
module flash_cmd_ctl_tb_top;
   localparam int ADDR_W = 11, DW = 8, NS = 4, SWD = 16, PC = 6, EC = 10;
   localparam int NW = NS * SWD;
   localparam int ETOT = NW + EC;

   logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
   logic [ADDR_W-1:0] addr = '0;
   logic [DW-1:0] wdata = '0, rdata;
   logic ready, low_supply = 1'b0;
   logic [NS-1:0] protect = '0;

   logic [7:0] mdl [NW];
   int n_tests = 0, n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   flash_cmd_ctl #(.ADDR_W(ADDR_W), .DW(DW), .SECTORS(NS), .SECTOR_WORDS(SWD),
      .PROG_CYC(PC), .ERASE_CYC(EC)) dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
      .addr(addr), .wdata(wdata), .rdata(rdata), .ready(ready),
      .low_supply(low_supply), .protect(protect));

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bw(logic [10:0] a, logic [7:0] d);
      @(negedge clk); cs_n = 0; wr_n = 0; addr = a; wdata = d;
      @(posedge clk); #1; cs_n = 1; wr_n = 1;
   endtask

   task automatic br(logic [10:0] a, output logic [7:0] d);
      @(negedge clk); cs_n = 0; rd_n = 0; addr = a; #1; d = rdata;
      @(posedge clk); #1; cs_n = 1; rd_n = 1;
   endtask

   task automatic unl();
      bw(11'h555, 8'hAA); bw(11'h2AA, 8'h55);
   endtask

   task automatic prog4(logic [10:0] a, logic [7:0] d);
      unl(); bw(11'h555, 8'hA0); bw(a, d);
   endtask

   task automatic sect_erase(int s);
      unl(); bw(11'h555, 8'h80); unl(); bw(11'(s * SWD), 8'h30);
   endtask

   task automatic wait_rdy(output int n);
      n = 0;
      while (!ready && n < 2000) begin n++; @(posedge clk); #1; end
   endtask

   function automatic logic [7:0] prog_result(logic [7:0] old, logic [7:0] d);
      return old & d;
   endfunction

   task automatic verify_all(string tag);
      logic [7:0] v;
      for (int i = 0; i < NW; i++) begin
         br(11'(i), v);
         chk(tag, v, mdl[i]);
      end
   endtask

   initial begin
      logic [7:0] v, v2;
      int n;
      void'($urandom(32'h5EED_0042));
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      #1;
      chk("R1 ready after reset", ready, 1);
      br(0, v); br(0, v2);
      chk("R1 reads stable after reset", v2, v);

      unl(); bw(11'h555, 8'h80); unl(); bw(11'h555, 8'h10);
      chk("R7 chip erase busy", ready, 0);
      wait_rdy(n);
      chk("R3 erase busy length", n, ETOT);
      for (int i = 0; i < NW; i++) mdl[i] = 8'hFF;
      verify_all("R7 chip erase all ones");

      prog4(3, 8'h5A);
      br(3, v); br(3, v2);
      chk("R4 data poll during program", v[7], 1);
      chk("R4 toggle between reads", v[6] ^ v2[6], 1);
      wait_rdy(n);
      chk("R3 program busy length", n, PC - 2);
      mdl[3] = prog_result(mdl[3], 8'h5A);
      br(3, v); chk("R2 program result", v, mdl[3]);
      br(3, v2); chk("R4 stable after done", v2, v);
      prog4(3, 8'h0F); wait_rdy(n);
      mdl[3] = prog_result(mdl[3], 8'h0F);
      br(3, v); chk("R2 program ANDs bits", v, 8'h0A);

      bw(11'h555, 8'hAA); bw(11'h2AA, 8'h56); bw(11'h555, 8'hA0); bw(5, 8'h00);
      chk("R11 broken sequence stays ready", ready, 1);
      br(5, v); chk("R11 broken sequence no write", v, 8'hFF);
      unl(); bw(0, 8'hF0); bw(11'h555, 8'hA0); bw(5, 8'h00);
      br(5, v); chk("R11 cancel returns to read", v, 8'hFF);

      unl(); bw(11'h555, 8'h20); bw(0, 8'hA0); bw(7, 8'h33);
      chk("R5 bypass program busy", ready, 0);
      wait_rdy(n); mdl[7] = 8'h33;
      br(7, v); chk("R5 bypass program result", v, 8'h33);
      bw(0, 8'h90); bw(0, 8'h00); bw(0, 8'hA0); bw(8, 8'h00);
      chk("R5 exit bypass ignores short program", ready, 1);
      br(8, v); chk("R5 exit bypass data kept", v, 8'hFF);

      low_supply = 1; prog4(9, 8'h00); low_supply = 0;
      chk("R10 low supply no job", ready, 1);
      bw(9, 8'h00);
      chk("R10 no partial sequence", ready, 1);
      br(9, v); chk("R10 data kept", v, 8'hFF);

      protect = 4'b0010;
      prog4(18, 8'h00);
      chk("R9 protected program refused", ready, 1);
      sect_erase(1);
      chk("R9 protected erase refused", ready, 1);
      br(18, v); chk("R9 protected data kept", v, 8'hFF);
      protect = 4'b0000;

      prog4(33, 8'h3C); wait_rdy(n); mdl[33] = 8'h3C;
      prog4(48, 8'h11); wait_rdy(n); mdl[48] = 8'h11;
      prog4(17, 8'h44); wait_rdy(n); mdl[17] = 8'h44;
      sect_erase(2);
      br(40, v);
      chk("R6 erase poll bit", v[7], 0);
      wait_rdy(n);
      chk("R3 sector erase length", n, ETOT - 1);
      for (int i = 32; i < 48; i++) mdl[i] = 8'hFF;
      verify_all("R6 sector erase only target");

      protect = 4'b0010;
      unl(); bw(11'h555, 8'h80); unl(); bw(11'h555, 8'h10);
      wait_rdy(n);
      for (int i = 0; i < NW; i++) if (i / SWD != 1) mdl[i] = 8'hFF;
      protect = 4'b0000;
      verify_all("R7 chip erase skips protected");

      prog4(32, 8'h00); wait_rdy(n); mdl[32] = 8'h00;
      prog4(5, 8'h77); wait_rdy(n); mdl[5] = 8'h77;
      sect_erase(2);
      repeat (5) @(posedge clk);
      #1; bw(0, 8'hB0);
      chk("R8 park sets ready", ready, 1);
      br(33, v); chk("R8 parked sector poll bit", v[7], 1);
      br(5, v); chk("R8 other sector readable", v, mdl[5]);
      prog4(6, 8'hC3); wait_rdy(n); mdl[6] = 8'hC3;
      chk("R8 back to parked", ready, 1);
      br(6, v); chk("R8 program while parked", v, 8'hC3);
      prog4(34, 8'h00);
      chk("R8 erasing sector refuses program", ready, 1);
      bw(0, 8'h30);
      chk("R8 continue busy", ready, 0);
      wait_rdy(n);
      for (int i = 32; i < 48; i++) mdl[i] = 8'hFF;
      verify_all("R8 erase completes");

      prog4(10, 8'h00);
      repeat (2) @(posedge clk);
      @(negedge clk); rst_n = 0;
      @(negedge clk); rst_n = 1; #1;
      chk("R1 ready after abort", ready, 1);
      br(10, v); chk("R1 aborted word kept", v, mdl[10]);

      for (int it = 0; it < 60; it++) begin
         logic [7:0] d;
         logic [5:0] a;
         int op;
         protect = 4'($urandom % 16);
         a  = 6'($urandom % NW);
         d  = 8'($urandom % 256);
         op = $urandom % 4;
         if (op < 2) begin
            prog4(11'(a), d);
         end else if (op == 2) begin
            unl(); bw(11'h555, 8'h20); bw(0, 8'hA0); bw(11'(a), d);
         end else begin
            sect_erase(a / SWD);
         end
         wait_rdy(n);
         if (op == 2) begin bw(0, 8'h90); bw(0, 8'h00); end
         if (!protect[a / SWD]) begin
            if (op == 3) for (int i = 0; i < SWD; i++) mdl[(a / SWD) * SWD + i] = 8'hFF;
            else mdl[a] = prog_result(mdl[a], d);
         end
         br(11'(a), v);
         chk(op == 3 ? "R6 R9 random erase" : "R2 R9 random program", v, mdl[a]);
      end
      protect = '0;
      verify_all("R2 random final array");

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule